// File: doc/BRIEF.md
# Dual-Threshold Hit Pair Matcher

This block turns pairs of threshold-crossing times into single detector hits. Every channel owns two time queues. One holds the times at which the signal crossed the upper discriminator level. The other holds the times at which it crossed the lower level. Upstream logic pushes 40-bit times into these queues, and within one channel the times arrive in time order.

A controller walks the channels in a circle. On each channel it waits for an upper-level time, then compares it with the head of that channel's lower-level queue. A lower-level time that is earlier than the upper one is thrown away, and the search goes on with the next one. A lower-level time that is later by more than the programmable window costs both entries. A lower-level time that lies inside the window yields one hit record. The record is written as two 32-bit words with a one-cycle strobe. It holds the channel number, the upper-level time and a rise value, which is the lower-minus-upper difference clipped to 8 bits.

Top module: `hit_pair_matcher`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is low, and every queue is empty.
- R2: Each channel has an upper queue of 8 entries and a lower queue of 16 entries. Each queue is served first-in first-out, and a push into a full queue is dropped.
- R3: Channels are visited in ascending order, wrapping from the last channel to channel 0. A channel whose upper queue is empty is passed over in a single cycle.
- R4: When a channel holds an upper-level time and its lower queue is empty, the controller stays on that channel. No other channel produces a record until a lower-level time arrives there.
- R5: If the lower head is earlier than the upper head, only the lower entry is removed, and the comparison repeats with the next lower entry.
- R6: If the lower head minus the upper head is greater than `match_window`, both entries are removed and no record is produced.
- R7: If the lower head minus the upper head is between 0 and `match_window`, both bounds included, both entries are removed and exactly one record is produced.
- R8: The rise field equals the lower-minus-upper difference when that difference is below 255, and 255 otherwise.
- R9: Word 0 has bits 31:30 = 2'b10, bits 29:24 = channel number, bits 23:20 = 0, bits 19:12 = rise, bits 11:8 = 0 and bits 7:0 = bits 39:32 of the upper-level time. Word 1 holds bits 31:0 of the upper-level time.
- R10: Each record appears as a single-cycle pulse on `out_valid`, with both words valid in that cycle. Records leave in the order in which the controller decides them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hi_push | input | 1 | Push an upper-level time |
| hi_ch | input | 6 | Channel for the upper-level push |
| hi_time | input | 40 | Upper-level crossing time |
| lo_push | input | 1 | Push a lower-level time |
| lo_ch | input | 6 | Channel for the lower-level push |
| lo_time | input | 40 | Lower-level crossing time |
| match_window | input | 12 | Largest accepted lower-minus-upper difference |
| out_valid | output | 1 | Record strobe |
| out_word0 | output | 32 | Record word 0: channel, rise, high time byte |
| out_word1 | output | 32 | Record word 1: low 32 bits of time |

## Verification
A new lower-level time can be written into a channel's lower queue in the same cycle that the controller removes an early entry from that same queue. To provoke this, an upper-level time is parked alone on one channel so that the controller waits there. Three lower-level times are then pushed into that channel on back-to-back cycles, and the first two are too early. Each early entry is therefore popped in the very cycle the next one is written. The case is judged correct when exactly one record appears, carrying the third time's difference, and no record follows it.

// File: rtl/hpm_pkg.sv
package hpm_pkg;
  typedef enum logic {ST_SCAN, ST_MATCH} hpm_state_t;
  localparam int RISE_W = 8;
  localparam logic [1:0] REC_TAG = 2'b10;
endpackage

// File: rtl/hpm_queue_bank.sv
// Per-channel FIFOs sharing one memory. NCH and DEPTH must be powers of two.
module hpm_queue_bank #(
  parameter int NCH   = 64,
  parameter int DEPTH = 8,
  parameter int DW    = 40,
  localparam int CW   = $clog2(NCH),
  localparam int PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [CW-1:0] push_ch,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [CW-1:0] sel_ch,
  output logic [DW-1:0] head_data,
  output logic [NCH-1:0] empty
);
  localparam int NW = PW + 1;

  logic [DW-1:0] mem [NCH*DEPTH];
  logic [PW-1:0] wptr [NCH];
  logic [PW-1:0] rptr [NCH];
  logic [NW-1:0] cnt  [NCH];
  logic          push_ok;

  assign push_ok = push && (cnt[push_ch] != NW'(DEPTH));

  always_ff @(posedge clk) begin
    if (push_ok) mem[{push_ch, wptr[push_ch]}] <= push_data;
  end

  assign head_data = mem[{sel_ch, rptr[sel_ch]}];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_g, rd_g;
    assign wr_g = push_ok && (push_ch == CW'(g));
    assign rd_g = pop && (sel_ch == CW'(g));
    assign empty[g] = (cnt[g] == '0);
    always_ff @(posedge clk) begin
      if (rst) begin
        wptr[g] <= '0;
        rptr[g] <= '0;
        cnt[g]  <= '0;
      end else begin
        if (wr_g) wptr[g] <= wptr[g] + 1'b1;
        if (rd_g) rptr[g] <= rptr[g] + 1'b1;
        cnt[g] <= cnt[g] + NW'(wr_g) - NW'(rd_g);
      end
    end
  end
endmodule

// File: rtl/hpm_pack.sv
module hpm_pack #(
  parameter int CW = 6,
  parameter int TW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          emit,
  input  logic [CW-1:0] ch,
  input  logic [TW-1:0] t_hi,
  input  logic [TW-1:0] diff,
  output logic          out_valid,
  output logic [31:0]   out_word0,
  output logic [31:0]   out_word1
);
  import hpm_pkg::*;

  logic [RISE_W-1:0] rise;
  logic [31:0]       w0_n;

  assign rise = (|diff[TW-1:RISE_W]) ? '1 : diff[RISE_W-1:0];
  assign w0_n = {REC_TAG, 6'(ch), 4'h0, rise, 4'h0, t_hi[39:32]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word0 <= '0;
      out_word1 <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_word0 <= w0_n;
        out_word1 <= t_hi[31:0];
      end
    end
  end
endmodule

// File: rtl/hit_pair_matcher.sv
module hit_pair_matcher #(
  parameter int NCH    = 64,
  parameter int HDEPTH = 8,
  parameter int LDEPTH = 16,
  parameter int TW     = 40,
  parameter int WINW   = 12,
  localparam int CW    = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hi_push,
  input  logic [CW-1:0]   hi_ch,
  input  logic [TW-1:0]   hi_time,
  input  logic            lo_push,
  input  logic [CW-1:0]   lo_ch,
  input  logic [TW-1:0]   lo_time,
  input  logic [WINW-1:0] match_window,
  output logic            out_valid,
  output logic [31:0]     out_word0,
  output logic [31:0]     out_word1
);
  import hpm_pkg::*;

  hpm_state_t     state, state_n;
  logic [CW-1:0]  cur_ch;
  logic [TW-1:0]  hi_head, lo_head, diff;
  logic [NCH-1:0] hi_empty, lo_empty;
  logic           hi_pop, lo_pop, emit, adv, early, in_win;

  hpm_queue_bank #(.NCH(NCH), .DEPTH(HDEPTH), .DW(TW)) u_hiq (
    .clk(clk), .rst(rst), .push(hi_push), .push_ch(hi_ch), .push_data(hi_time),
    .pop(hi_pop), .sel_ch(cur_ch), .head_data(hi_head), .empty(hi_empty));

  hpm_queue_bank #(.NCH(NCH), .DEPTH(LDEPTH), .DW(TW)) u_loq (
    .clk(clk), .rst(rst), .push(lo_push), .push_ch(lo_ch), .push_data(lo_time),
    .pop(lo_pop), .sel_ch(cur_ch), .head_data(lo_head), .empty(lo_empty));

  assign early  = lo_head < hi_head;
  assign diff   = lo_head - hi_head;
  assign in_win = diff <= TW'(match_window);

  always_comb begin
    state_n = state;
    hi_pop  = 1'b0;
    lo_pop  = 1'b0;
    emit    = 1'b0;
    adv     = 1'b0;
    case (state)
      ST_SCAN: begin
        if (hi_empty[cur_ch]) adv = 1'b1;
        else                  state_n = ST_MATCH;
      end
      ST_MATCH: begin
        if (!lo_empty[cur_ch]) begin
          if (early) begin
            lo_pop = 1'b1;
          end else begin
            hi_pop  = 1'b1;
            lo_pop  = 1'b1;
            emit    = in_win;
            adv     = 1'b1;
            state_n = ST_SCAN;
          end
        end
      end
      default: state_n = ST_SCAN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_SCAN;
      cur_ch <= '0;
    end else begin
      state  <= state_n;
      cur_ch <= cur_ch + CW'(adv);
    end
  end

  hpm_pack #(.CW(CW), .TW(TW)) u_pack (
    .clk(clk), .rst(rst), .emit(emit), .ch(cur_ch), .t_hi(hi_head), .diff(diff),
    .out_valid(out_valid), .out_word0(out_word0), .out_word1(out_word1));
endmodule

// File: rtl/hpm_checker.sv
module hpm_checker #(
  parameter int CW   = 6,
  parameter int WINW = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            in_match,
  input logic [CW-1:0]   cur_ch,
  input logic            hi_empty_cur,
  input logic            lo_empty_cur,
  input logic            hi_pop,
  input logic            lo_pop,
  input logic            out_valid,
  input logic [31:0]     out_word0,
  input logic [WINW-1:0] match_window
);
  // R7: a record always follows a cycle that consumed both heads
  p_emit_pops_both_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(hi_pop && lo_pop));
  // R2: no queue is ever read while empty
  p_hi_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    hi_pop |-> !hi_empty_cur);
  p_lo_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    lo_pop |-> !lo_empty_cur);
  // R3: an idle channel costs exactly one cycle
  p_skip_advance_r3: assert property (@(posedge clk) disable iff (rst)
    (!in_match && hi_empty_cur) |=> cur_ch == CW'($past(cur_ch) + 1'b1));
  // R4: controller stays put while the lower queue is empty
  p_wait_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (in_match && lo_empty_cur) |=> (in_match && $stable(cur_ch)));
  // R8: emitted rise never exceeds the window in force at decision time
  p_rise_in_window_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ({{(WINW > 8 ? WINW-8 : 0){1'b0}}, out_word0[19:12]} <= $past(match_window)));
  // R9: tag and reserved fields
  p_word0_fields_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_word0[31:30] == 2'b10 && out_word0[23:20] == 4'h0 && out_word0[11:8] == 4'h0));
  // R10: a record strobe lasts one cycle
  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind hit_pair_matcher hpm_checker #(.CW(CW), .WINW(WINW)) u_hpm_chk (
  .clk(clk), .rst(rst), .in_match(state == hpm_pkg::ST_MATCH), .cur_ch(cur_ch),
  .hi_empty_cur(hi_empty[cur_ch]), .lo_empty_cur(lo_empty[cur_ch]),
  .hi_pop(hi_pop), .lo_pop(lo_pop), .out_valid(out_valid), .out_word0(out_word0),
  .match_window(match_window));

// File: tb/hit_pair_matcher_bench.sv
module hit_pair_matcher_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hi_push = 1'b0, lo_push = 1'b0;
  logic [5:0]  hi_ch = '0, lo_ch = '0;
  logic [39:0] hi_time = '0, lo_time = '0;
  logic [11:0] match_window = 12'd20;
  logic        out_valid;
  logic [31:0] out_word0, out_word1;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  hit_pair_matcher u_hit_pair_matcher (
    .clk(clk), .rst(rst), .hi_push(hi_push), .hi_ch(hi_ch), .hi_time(hi_time),
    .lo_push(lo_push), .lo_ch(lo_ch), .lo_time(lo_time), .match_window(match_window),
    .out_valid(out_valid), .out_word0(out_word0), .out_word1(out_word1));

  function automatic logic [63:0] mk(input int ch, input logic [39:0] t, input logic [39:0] d);
    logic [7:0] rise;
    rise = (d > 40'd255) ? 8'hFF : d[7:0];
    return {2'b10, 6'(ch), 4'h0, rise, 4'h0, t[39:32], t[31:0]};
  endfunction

  task automatic expect_rec(input int ch, input logic [39:0] t, input logic [39:0] d, input string tag);
    exp_q.push_back(mk(ch, t, d));
    tag_q.push_back(tag);
  endtask

  task automatic push_hi(input int ch, input logic [39:0] t);
    hi_push = 1'b1; hi_ch = 6'(ch); hi_time = t;
    @(negedge clk);
    hi_push = 1'b0;
  endtask

  task automatic push_lo(input int ch, input logic [39:0] t);
    lo_push = 1'b1; lo_ch = 6'(ch); lo_time = t;
    @(negedge clk);
    lo_push = 1'b0;
  endtask

  task automatic drain(input int limit, input string tag);
    int n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL %s: %0d records missing, expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  // monitor: compares every record with the scoreboard head
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R6/R10: unexpected record %h_%h, expected none", out_word0, out_word1);
      end else begin
        logic [63:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_word0, out_word1} !== e) begin
          bad++;
          $display("FAIL %s: got %h_%h, expected %h_%h", t, out_word0, out_word1, e[63:32], e[31:0]);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_valid=%b during reset, expected 0", out_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
    end

    // R7 R9: basic match
    expect_rec(5, 40'd990, 40'd10, "R7 basic match");
    push_lo(5, 40'd1000);
    push_hi(5, 40'd990);
    drain(80, "R3 R7 basic match");

    // R5: early low discarded, next low matches
    expect_rec(9, 40'd200, 40'd5, "R5 early low");
    push_lo(9, 40'd100);
    push_lo(9, 40'd205);
    push_hi(9, 40'd200);
    drain(80, "R5 early low");

    // R2: per-channel FIFO order
    expect_rec(22, 40'd8, 40'd2, "R2 order first");
    expect_rec(22, 40'd18, 40'd2, "R2 order second");
    push_lo(22, 40'd10);
    push_lo(22, 40'd20);
    push_hi(22, 40'd8);
    push_hi(22, 40'd18);
    drain(150, "R2 order");

    // R6: late low drops both; following pair proves the low entry went too
    push_lo(12, 40'd500);
    push_hi(12, 40'd100);
    repeat (100) @(negedge clk);
    expect_rec(12, 40'd495, 40'd10, "R6 both dropped");
    push_lo(12, 40'd505);
    push_hi(12, 40'd495);
    drain(80, "R6 both dropped");

    // R7: window bounds
    expect_rec(30, 40'd1000, 40'd20, "R7 diff equals window");
    push_lo(30, 40'd1020);
    push_hi(30, 40'd1000);
    push_lo(31, 40'd1021);
    push_hi(31, 40'd1000);
    drain(150, "R7 window edge");
    repeat (80) @(negedge clk);
    expect_rec(33, 40'd777, 40'd0, "R7 zero difference");
    push_lo(33, 40'd777);
    push_hi(33, 40'd777);
    drain(80, "R7 zero difference");

    // R8: saturated rise
    match_window = 12'd1000;
    expect_rec(20, 40'd2000, 40'd300, "R8 saturated rise");
    push_lo(20, 40'd2300);
    push_hi(20, 40'd2000);
    drain(80, "R8 saturated rise");
    expect_rec(21, 40'd3000, 40'd255, "R8 rise at 255");
    push_lo(21, 40'd3255);
    push_hi(21, 40'd3000);
    drain(80, "R8 rise at 255");
    match_window = 12'd20;

    // R9: upper time bits and last channel
    expect_rec(63, 40'h12_3456_7890, 40'd3, "R9 field layout");
    push_lo(63, 40'h12_3456_7893);
    push_hi(63, 40'h12_3456_7890);
    drain(80, "R9 field layout");

    // R4: controller waits on a channel lacking a low entry
    push_hi(7, 40'd300);
    push_lo(8, 40'd410);
    push_hi(8, 40'd400);
    repeat (150) @(negedge clk);
    expect_rec(7, 40'd300, 40'd2, "R4 waiting channel first");
    expect_rec(8, 40'd400, 40'd10, "R4 next channel after");
    push_lo(7, 40'd302);
    drain(100, "R4 wait and order");

    // push and pop of the same lower queue in one cycle
    push_hi(14, 40'd1000);
    repeat (70) @(negedge clk);
    expect_rec(14, 40'd1000, 40'd5, "R5 push during pop");
    push_lo(14, 40'd900);
    push_lo(14, 40'd950);
    push_lo(14, 40'd1005);
    drain(80, "R5 push during pop");
    repeat (100) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule